// File: doc/BRIEF.md
# Service-by-Read Watchdog Channel

This block is a single watchdog timer channel with a three-register bus view. A 16-bit down counter loses one count on each enabled tick. The tick is meant to come from an external tenth-second strobe. When the count runs out, the channel stops, flags itself as expired and emits a one-cycle expiry pulse.

There is no separate control register. Accesses themselves carry the control actions:

- Writing the limit register stores a new period and starts a countdown from it.
- Reading the counter register returns the present count and then reloads the counter from the limit. This is how software keeps the channel alive, and it also starts an idle channel.
- Reading the limit register has no side effect.

Tick generation, interrupt masking and any reset outputs belong to the surrounding logic.

Top module: `wdog_chan`

## Requirements
- R1: While running, the counter decreases by exactly one on each clock edge where `tick_en` is high, and keeps its value on edges where `tick_en` is low.
- R2: A tick that finds the counter at 1 or 0 sets the counter to 0, clears the running bit and sets the expired bit. In the cycle after that edge, `expire_pulse` is high for exactly one clock. After that the counter stays at 0.
- R3: A read with `reg_sel` = 0 (counter) returns the present count. At that edge it also loads the counter from the limit, sets the running bit and clears the expired bit.
- R4: A write with `reg_sel` = 1 (limit) stores `wr_data` as the limit and as the counter, sets running and clears expired. A read strobe in the same cycle does not block the write and returns the old limit.
- R5: A read with `reg_sel` = 1 returns the limit and changes neither the counter nor the status.
- R6: A read with `reg_sel` = 2 returns status, with bit 0 = running, bit 1 = expired and all higher bits zero. A read with `reg_sel` = 3 returns zero. Running and expired are never both set.
- R7: After reset the counter and the limit both hold 1. Running, expired and `expire_pulse` are 0.
- R8: Writes with `reg_sel` = 0, 2 or 3 change no state.
- R9: Writing a limit of 0 starts the channel, and the next tick expires it.
- R10: While the channel is idle or expired, ticks leave the counter and status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one pulse per count period |
| reg_sel | input | 2 | Register select: 0 counter, 1 limit, 2 status, 3 none |
| rd_en | input | 1 | Read strobe; read side effects happen at the clock edge |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Selected register value while `rd_en` is high, else zero |
| expire_pulse | output | 1 | One-cycle pulse after the channel expires |

## Verification
The embedded assertions check the following on every cycle:
- a limit write loads both registers and starts the channel;
- a counter read reloads from the limit;
- the counter holds when no tick arrives or the channel is not running;
- running and expired exclude each other;
- the expiry pulse lasts a single cycle and coincides with a zero count.

Some behaviours need the bench's scenarios to show them:
- the values returned through `rd_data`, including the count seen before a reload;
- that writes to the counter, status and unused selects really leave the state untouched;
- a limit of zero expiring on the next tick;
- the reset values;
- write priority over a simultaneous read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Register select codes; the bus decoder relies on these values.
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_LIMIT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } wd_sel_e;

    // Status bit positions, fixed for software.
    localparam int unsigned ST_RUN_BIT = 0;
    localparam int unsigned ST_EXP_BIT = 1;

endpackage

// File: rtl/wdog_evt.sv
module wdog_evt
    import wdog_pkg::*;
(
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [1:0] sel,
    output logic       do_load,
    output logic       do_reload
);

    // A limit write starts a new countdown; a counter read services the channel.
    always_comb begin
        do_load   = wr_en && (sel == SEL_LIMIT);
        do_reload = rd_en && (sel == SEL_COUNT) && !do_load;
    end

endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
    import wdog_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         rd_en,
    input  logic [1:0]   sel,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] lim,
    input  logic         run,
    input  logic         exp,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] stat;

    always_comb begin
        stat             = '0;
        stat[ST_RUN_BIT] = run;
        stat[ST_EXP_BIT] = exp;
        rd_data          = '0;
        if (rd_en) begin
            case (sel)
                SEL_COUNT:  rd_data = cnt;
                SEL_LIMIT:  rd_data = lim;
                SEL_STATUS: rd_data = stat;
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_chan.sv
module wdog_chan
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned RESET_COUNT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       reg_sel,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             expire_pulse
);

    localparam logic [CNT_W-1:0] RST_V = CNT_W'(RESET_COUNT);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             run;
        logic             exp;
        logic             pulse;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     do_load, do_reload;

    wdog_evt evt_i (
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .sel       (reg_sel),
        .do_load   (do_load),
        .do_reload (do_reload)
    );

    wdog_rdmux #(.W(CNT_W)) rdmux_i (
        .rd_en   (rd_en),
        .sel     (reg_sel),
        .cnt     (st_q.cnt),
        .lim     (st_q.lim),
        .run     (st_q.run),
        .exp     (st_q.exp),
        .rd_data (rd_data)
    );

    // Next-state: load beats reload beats counting.
    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (do_load) begin
            st_d.lim = wr_data;
            st_d.cnt = wr_data;
            st_d.run = 1'b1;
            st_d.exp = 1'b0;
        end else if (do_reload) begin
            st_d.cnt = st_q.lim;
            st_d.run = 1'b1;
            st_d.exp = 1'b0;
        end else if (st_q.run && tick_en) begin
            if (st_q.cnt <= ONE_V) begin
                st_d.cnt   = '0;
                st_d.run   = 1'b0;
                st_d.exp   = 1'b1;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE_V;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= RST_V;
            st_q.lim   <= RST_V;
            st_q.run   <= 1'b0;
            st_q.exp   <= 1'b0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire_pulse = st_q.pulse;

    // R4: a limit write lands in both registers and starts the channel
    a_r4_limit_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == SEL_LIMIT) |=>
        (st_q.cnt == $past(wr_data) && st_q.lim == $past(wr_data) && st_q.run && !st_q.exp));

    // R3: a counter read reloads from the limit
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && reg_sel == SEL_COUNT) |=>
        (st_q.cnt == $past(st_q.lim) && st_q.run && !st_q.exp));

    // R2: the expiry pulse lasts one cycle and goes with a zero count
    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |=> !expire_pulse);
    a_r2_pulse_expired: assert property (@(posedge clk) disable iff (!rst_n)
        expire_pulse |-> (st_q.exp && st_q.cnt == '0));

    // R6: running and expired never coincide
    a_r6_run_exp_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.run && st_q.exp));

    // R1: no tick, no change
    a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !do_load && !do_reload) |=> $stable(st_q.cnt));

    // R10: a stopped channel ignores ticks
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !do_load && !do_reload) |=>
        ($stable(st_q.cnt) && $stable(st_q.exp)));

endmodule

// File: tb/wdog_chan_tb.sv
module wdog_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        expire_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wdog_chan dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .reg_sel      (reg_sel),
        .rd_en        (rd_en),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .expire_pulse (expire_pulse)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_in();
        rd_en = 1'b0; wr_en = 1'b0; tick_en = 1'b0; reg_sel = 2'd0; wr_data = '0;
    endtask

    // Vector fields: req[44:41] op[40:39] sel[38:37] tick[36] data[35:20] unused[19:16] exp[15:0]
    // op: 0 idle, 1 read (check rd_data), 2 write
    localparam int NV = 35;
    localparam logic [44:0] VEC [NV] = '{
        {4'd7, 2'd1, 2'd1, 1'b0, 16'h0000, 4'h0, 16'h0001}, // R7 limit reset value
        {4'd7, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0000}, // R7 status reset value
        {4'd7, 2'd1, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0001}, // R7 counter reset value, reload starts
        {4'd3, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0001}, // R3 read started channel
        {4'd4, 2'd2, 2'd1, 1'b0, 16'h0005, 4'h0, 16'h0000}, // R4 write limit 5
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // R1 tick -> 4
        {4'd1, 2'd0, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0000}, // R1 no tick
        {4'd5, 2'd1, 2'd1, 1'b0, 16'h0000, 4'h0, 16'h0005}, // R5 limit read
        {4'd1, 2'd1, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0004}, // R1 count is 4, reload 5
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000},
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000},
        {4'd1, 2'd1, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0003}, // R1 two ticks -> 3
        {4'd3, 2'd1, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0005}, // R3 reload gave 5
        {4'd8, 2'd2, 2'd0, 1'b0, 16'h0077, 4'h0, 16'h0000}, // R8 write counter sel
        {4'd8, 2'd2, 2'd2, 1'b0, 16'h00FF, 4'h0, 16'h0000}, // R8 write status sel
        {4'd8, 2'd2, 2'd3, 1'b0, 16'h1234, 4'h0, 16'h0000}, // R8 write unused sel
        {4'd8, 2'd1, 2'd1, 1'b0, 16'h0000, 4'h0, 16'h0005},
        {4'd8, 2'd1, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0005},
        {4'd8, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0001},
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // 5->4
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // 4->3
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // 3->2
        {4'd1, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // 2->1
        {4'd2, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // 1->0 expire
        {4'd2, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0002}, // R2 expired, stopped
        {4'd5, 2'd1, 2'd1, 1'b0, 16'h0000, 4'h0, 16'h0005}, // R5 limit intact
        {4'd10,2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // R10 tick when expired
        {4'd6, 2'd1, 2'd3, 1'b0, 16'h0000, 4'h0, 16'h0000}, // R6 unused sel reads 0
        {4'd10,2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0002}, // R10 status unchanged
        {4'd2, 2'd1, 2'd0, 1'b0, 16'h0000, 4'h0, 16'h0000}, // R2 counter held 0, reload
        {4'd3, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0001}, // R3 expired cleared
        {4'd9, 2'd2, 2'd1, 1'b0, 16'h0000, 4'h0, 16'h0000}, // R9 write limit 0
        {4'd9, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0001}, // R9 running
        {4'd9, 2'd0, 2'd0, 1'b1, 16'h0000, 4'h0, 16'h0000}, // R9 single tick
        {4'd9, 2'd1, 2'd2, 1'b0, 16'h0000, 4'h0, 16'h0002}  // R9 expired
    };

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        finish_run();
    end

    initial begin
        idle_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R7 pulse after reset", {15'd0, expire_pulse}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            logic [44:0] v;
            v       = VEC[i];
            rd_en   = (v[40:39] == 2'd1);
            wr_en   = (v[40:39] == 2'd2);
            reg_sel = v[38:37];
            tick_en = v[36];
            wr_data = v[35:20];
            #1;
            if (v[40:39] == 2'd1)
                chk($sformatf("R%0d vector %0d", v[44:41], i), rd_data, v[15:0]);
            @(posedge clk);
            @(negedge clk);
        end
        idle_in();

        // R2: pulse timing with limit 2
        wr_en = 1'b1; reg_sel = 2'd1; wr_data = 16'd2;
        @(posedge clk); @(negedge clk);
        idle_in(); tick_en = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 no pulse before zero", {15'd0, expire_pulse}, 16'd0);
        @(posedge clk); @(negedge clk);
        idle_in();
        chk("R2 pulse high after expiring tick", {15'd0, expire_pulse}, 16'd1);
        @(posedge clk); @(negedge clk);
        chk("R2 pulse lasts one cycle", {15'd0, expire_pulse}, 16'd0);

        // R4: write wins over simultaneous read of limit
        rd_en = 1'b1; wr_en = 1'b1; reg_sel = 2'd1; wr_data = 16'd9;
        #1;
        chk("R4 simultaneous read sees old limit", rd_data, 16'd2);
        @(posedge clk); @(negedge clk);
        idle_in(); rd_en = 1'b1; reg_sel = 2'd1;
        #1;
        chk("R4 new limit stored", rd_data, 16'd9);
        @(posedge clk); @(negedge clk);
        idle_in();

        // R7 and R10: reset mid-run, then ticks while idle
        tick_en = 1'b1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle_in(); tick_en = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        idle_in(); rd_en = 1'b1; reg_sel = 2'd2;
        #1;
        chk("R10 idle ticks do not expire", rd_data, 16'd0);
        reg_sel = 2'd1;
        #1;
        chk("R7 limit back to 1", rd_data, 16'd1);
        reg_sel = 2'd0;
        #1;
        chk("R10 idle counter still 1", rd_data, 16'd1);
        @(posedge clk); @(negedge clk);
        idle_in();
        chk("R7 no pulse after reset", {15'd0, expire_pulse}, 16'd0);

        finish_run();
    end

endmodule